// File: doc/BRIEF.md
# Display Character Fetch and Pixel Serializer

This block sits on the memory bus between a CPU and its memory and turns display-file bytes into a serial pixel stream. The display file is code that the CPU runs from the upper half of the address space. Every opcode fetch from that half is sent to the same offset in the lower half. A fetched byte with bit 6 clear reaches the CPU unchanged and is executed. A fetched byte with bit 6 set is a character: the CPU gets a NOP (0x00) in its place, and the byte is held for the refresh cycle that follows.

During that refresh cycle the block puts a font address on the memory bus. The address is built from the I register, the six-bit character code and the scan-line counter. The returned font byte is captured and, once the refresh ends, loaded into a shift register. Bit 7 of the character byte decides whether the pattern is complemented first. The pattern then leaves one pixel per pixel-clock enable, most significant bit first. The block also raises a maskable interrupt request whenever a refresh cycle carries a refresh address with bit 6 clear.

The control is a three-state machine. `ST_IDLE` means no character is held. `ST_ARMED` means a character is latched and waits for the refresh. `ST_FONT` means the font read is in progress. The transitions are:
- CAPTURE (`ST_IDLE` or `ST_ARMED` to `ST_ARMED`): an upper-half fetch with bit 6 set.
- REFRESH (`ST_ARMED` to `ST_FONT`): a refresh cycle begins.
- LOAD (`ST_FONT` to `ST_IDLE`, or to `ST_ARMED` if a CAPTURE happens in the same cycle): the refresh ends and the shifter is loaded.

Top module: `dfetch_top`

## Requirements
- R1: During an opcode fetch (`cpu_m1`=1, `cpu_mreq`=1, `cpu_rfsh`=0) with `cpu_addr[15]`=1, `mem_addr` equals `cpu_addr` with bit 15 cleared. In every other non-font cycle, `mem_addr` equals `cpu_addr`.
- R2: A byte fetched from the upper half with bit 6 clear is passed to `cpu_rdata` unchanged. Lower-half fetches and non-fetch reads are also passed unchanged.
- R3: A byte fetched from the upper half with bit 6 set is replaced on `cpu_rdata` by 0x00.
- R4: In the refresh cycle (`cpu_rfsh`=1, `cpu_mreq`=1) after such a fetch, `font_fetch`=1. In that cycle `mem_addr` is {`cpu_ireg[7:1]`, char[5:0], `line_cnt[2:0]`}, with the line counter in bits 2..0, the code in bits 8..3 and the I register in bits 15..9.
- R5: The font byte is loaded into the shifter at the first clock edge after the refresh ends. The next value of `pix_dark` is bit 7 of the loaded pattern. Each edge with `pix_en`=1 moves the next lower bit out, and zeros follow the last bit.
- R6: If bit 7 of the character byte is 1, the loaded pattern is the complement of the font byte.
- R7: While `sync_act`=1, `pix_dark` is 1 regardless of the shifter.
- R8: `int_req` is 1 for the cycle after a clock edge that sampled a refresh cycle with `cpu_addr[6]`=0. After any other edge it is 0.
- R9: After an upper-half fetch with bit 6 clear, the following refresh cycle has `font_fetch`=0 and `mem_addr`=`cpu_addr`, and no pattern is loaded (`pix_dark` stays 0 once the shifter has emptied).
- R10: During reset, `font_fetch`, `int_req` and `pix_dark` (with `sync_act`=0) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_m1 | input | 1 | Opcode fetch cycle, active high |
| cpu_mreq | input | 1 | Memory request, active high |
| cpu_rfsh | input | 1 | Refresh cycle, active high |
| cpu_ireg | input | 8 | Current I register value |
| line_cnt | input | 3 | Scan line within the character row |
| sync_act | input | 1 | Combined sync active |
| pix_en | input | 1 | Pixel clock enable |
| mem_rdata | input | 8 | Data returned by memory |
| mem_addr | output | 16 | Address presented to memory |
| cpu_rdata | output | 8 | Data returned to the CPU |
| font_fetch | output | 1 | A font address is on the memory bus |
| pix_dark | output | 1 | Serial pixel, 1 = dark |
| int_req | output | 1 | Maskable interrupt request |

## Verification
A wrong state in the machine shows up within one refresh cycle. A lost CAPTURE leaves `font_fetch` low and `mem_addr` carrying the refresh address. A spurious one replaces a refresh address with a font address. A wrong latched character is visible in the same refresh cycle through `mem_addr[8:3]`, and a wrong inversion flag is visible one edge after the refresh, in the first pixel. Shifter faults surface bit by bit on `pix_dark` within eight enables. The sweep covers every character code with both inversion settings, so any mis-wired address or data bit is exposed.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FONT  = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/dfetch_bus_mux.sv
module dfetch_bus_mux #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] NOP_CODE = '0
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              upper_fetch,
    input  logic              char_hit,
    input  logic              font_sel,
    input  logic [ADDR_W-1:0] font_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] cpu_rdata
);
    always_comb begin
        if (font_sel) begin
            mem_addr = font_addr;
        end else if (upper_fetch) begin
            mem_addr = cpu_addr;
            mem_addr[ADDR_W-1] = 1'b0;
        end else begin
            mem_addr = cpu_addr;
        end
    end

    always_comb begin
        cpu_rdata = char_hit ? NOP_CODE : mem_rdata;
    end

    // a redirected fetch never reaches the upper half
    always_comb begin
        if (upper_fetch && !font_sel) begin
            assert_redirect_low_R1: assert (mem_addr[ADDR_W-1] == 1'b0);
        end
    end
endmodule

// File: rtl/dfetch_seq.sv
module dfetch_seq
    import dfetch_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MARK_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upper_fetch,
    input  logic              refresh,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              char_hit,
    output logic              font_sel,
    output logic              load_pulse,
    output logic [DATA_W-1:0] char_q,
    output logic [DATA_W-1:0] font_q
);
    fetch_state_e state_q, state_d;

    assign char_hit = upper_fetch && mem_rdata[MARK_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            char_q  <= '0;
            font_q  <= '0;
        end else begin
            state_q <= state_d;
            if (char_hit) char_q <= mem_rdata;
            if (font_sel) font_q <= mem_rdata;
        end
    end

    always_comb begin
        state_d    = state_q;
        font_sel   = 1'b0;
        load_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (char_hit) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                font_sel = refresh;
                if (refresh) state_d = ST_FONT;
            end
            ST_FONT: begin
                font_sel = refresh;
                if (!refresh) begin
                    load_pulse = 1'b1;
                    state_d    = char_hit ? ST_ARMED : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // the font state is only entered from a sampled refresh cycle
    assert_font_after_refresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FONT) |-> $past(refresh));

    // a character is only armed after a display byte was seen
    assert_armed_after_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(state_q) && state_q == ST_ARMED) |-> $past(char_hit));
endmodule

// File: rtl/dfetch_shift.sv
module dfetch_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              pix_en,
    output logic              pix_msb
);
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      sh_q <= '0;
        else if (load)   sh_q <= load_val;
        else if (pix_en) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end

    assign pix_msb = sh_q[DATA_W-1];

    // the register holds whatever value was loaded on the previous edge
    assert_load_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pix_msb == $past(load_val[DATA_W-1])));

    // with no load and no enable the output pixel is frozen
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !pix_en) |=> $stable(pix_msb));
endmodule

// File: rtl/dfetch_top.sv
module dfetch_top
    import dfetch_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int LINE_W   = 3,
    parameter int CODE_W   = 6,
    parameter int MARK_BIT = 6,
    parameter int INV_BIT  = 7,
    parameter int IRQ_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_m1,
    input  logic              cpu_mreq,
    input  logic              cpu_rfsh,
    input  logic [DATA_W-1:0] cpu_ireg,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic              sync_act,
    input  logic              pix_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              font_fetch,
    output logic              pix_dark,
    output logic              int_req
);
    localparam int IHI_W = ADDR_W - CODE_W - LINE_W;

    logic              op_fetch, upper_fetch, refresh;
    logic              char_hit, font_sel, load_pulse;
    logic [DATA_W-1:0] char_q, font_q, load_val;
    logic [ADDR_W-1:0] font_addr;
    logic              pix_msb;
    logic              int_q;

    assign op_fetch    = cpu_m1 && cpu_mreq && !cpu_rfsh;
    assign upper_fetch = op_fetch && cpu_addr[ADDR_W-1];
    assign refresh     = cpu_rfsh && cpu_mreq;

    assign font_addr = {cpu_ireg[DATA_W-1 -: IHI_W], char_q[CODE_W-1:0], line_cnt};
    assign load_val  = font_q ^ {DATA_W{char_q[INV_BIT]}};

    dfetch_seq #(.DATA_W(DATA_W), .MARK_BIT(MARK_BIT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .upper_fetch(upper_fetch),
        .refresh    (refresh),
        .mem_rdata  (mem_rdata),
        .char_hit   (char_hit),
        .font_sel   (font_sel),
        .load_pulse (load_pulse),
        .char_q     (char_q),
        .font_q     (font_q)
    );

    dfetch_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .cpu_addr   (cpu_addr),
        .upper_fetch(upper_fetch),
        .char_hit   (char_hit),
        .font_sel   (font_sel),
        .font_addr  (font_addr),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .cpu_rdata  (cpu_rdata)
    );

    dfetch_shift #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_pulse),
        .load_val(load_val),
        .pix_en  (pix_en),
        .pix_msb (pix_msb)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) int_q <= 1'b0;
        else        int_q <= refresh && !cpu_addr[IRQ_BIT];
    end

    assign font_fetch = font_sel;
    assign int_req    = int_q;
    assign pix_dark   = sync_act || pix_msb;

    // a display byte seen by the sequencer always yields a NOP at the CPU
    assert_nop_on_char_R3: assert property (@(posedge clk) disable iff (!rst_n)
        char_hit |-> (cpu_rdata == '0));

    // the font address is only driven inside a refresh cycle
    assert_font_in_refresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
        font_fetch |-> (cpu_rfsh && cpu_mreq));

    // a rising interrupt request follows a sampled refresh cycle
    assert_int_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_req) |-> $past(cpu_rfsh && cpu_mreq));

    // the shifter is loaded only once the refresh has ended
    assert_load_after_rfsh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |-> !refresh);
endmodule

// File: tb/test_dfetch_top.sv
module test_dfetch_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic        cpu_m1, cpu_mreq, cpu_rfsh;
    logic [7:0]  cpu_ireg;
    logic [2:0]  line_cnt;
    logic        sync_act, pix_en;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  cpu_rdata;
    logic        font_fetch, pix_dark, int_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dfetch_top i_dfetch_top (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_m1(cpu_m1),
        .cpu_mreq(cpu_mreq), .cpu_rfsh(cpu_rfsh), .cpu_ireg(cpu_ireg),
        .line_cnt(line_cnt), .sync_act(sync_act), .pix_en(pix_en),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .cpu_rdata(cpu_rdata),
        .font_fetch(font_fetch), .pix_dark(pix_dark), .int_req(int_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic m1, input logic mreq, input logic rf,
                       input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_m1 = m1; cpu_mreq = mreq; cpu_rfsh = rf; cpu_addr = a; mem_rdata = d;
        #1;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cpu_addr = '0; cpu_m1 = 0; cpu_mreq = 0; cpu_rfsh = 0;
        cpu_ireg = '0; line_cnt = '0; sync_act = 0; pix_en = 0; mem_rdata = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 font_fetch", font_fetch, 0);
        check("R10 int_req", int_req, 0);
        check("R10 pix_dark", pix_dark, 0);
        @(negedge clk); rst_n = 1'b1;

        for (int k = 0; k < 128; k++) begin
            logic [7:0]  chr, ir, fnt, pat;
            logic [15:0] fa, ra;
            chr = {k[6], 1'b1, k[5:0]};
            ir  = 8'((k * 11 + 3) & 8'hFF);
            fnt = 8'((k * 37 + 5) & 8'hFF);
            pat = k[6] ? ~fnt : fnt;
            fa  = 16'h8000 | 16'((k * 97) & 16'h7FFF);
            ra  = {ir, 1'b0, 7'(k ^ 7'h2A)};
            cpu_ireg = ir;
            line_cnt = 3'(k % 8);
            // fetch from the display file
            bus(1, 1, 0, fa, chr);
            check("R1 redirect", mem_addr, fa & 16'h7FFF);
            check("R3 nop", cpu_rdata, 8'h00);
            check("R4 no font in fetch", font_fetch, 0);
            // refresh cycle
            bus(0, 1, 1, ra, fnt);
            check("R4 font_fetch", font_fetch, 1);
            check("R4 font addr", mem_addr, {ir[7:1], chr[5:0], 3'(k % 8)});
            // refresh ended: the load happens at the end of this cycle
            bus(0, 0, 0, 16'h0000, 8'h00);
            check("R8 int", int_req, !ra[6]);
            check("R4 font off", font_fetch, 0);
            for (int b = 7; b >= 0; b--) begin
                @(negedge clk);
                pix_en = 1;
                sync_act = (k % 5 == 0) && (b == 3);
                #1;
                if (sync_act) check("R7 sync forces dark", pix_dark, 1);
                else check(k[6] ? "R6 inverted pixel" : "R5 pixel", pix_dark, pat[b]);
                if (b == 7) check("R8 int clears", int_req, 0);
            end
            @(negedge clk);
            sync_act = 0;
            #1;
            check("R5 zero fill", pix_dark, 0);
            pix_en = 0;
        end

        // D6 clear from the upper half: executed, nothing fetched
        for (int k = 0; k < 16; k++) begin
            logic [7:0] op;
            op = {k[0], 1'b0, 6'(k * 5)};
            bus(1, 1, 0, 16'hC000 + 16'(k), op);
            check("R2 pass opcode", cpu_rdata, op);
            check("R1 redirect", mem_addr, 16'h4000 + 16'(k));
            bus(0, 1, 1, 16'h3340 + 16'(k), 8'hFF);
            check("R9 no font fetch", font_fetch, 0);
            check("R9 refresh address kept", mem_addr, 16'h3340 + 16'(k));
            bus(0, 0, 0, 16'h0000, 8'h00);
            check("R8 int high bit", int_req, 0);
            @(negedge clk); pix_en = 1; #1;
            check("R9 no pixel load", pix_dark, 0);
            pix_en = 0;
        end

        // lower half fetch with D6 set passes unchanged
        bus(1, 1, 0, 16'h1234, 8'h45);
        check("R2 lower fetch data", cpu_rdata, 8'h45);
        check("R1 lower fetch addr", mem_addr, 16'h1234);
        bus(0, 1, 0, 16'hF00D, 8'h77);
        check("R2 plain read", cpu_rdata, 8'h77);
        check("R1 plain read addr", mem_addr, 16'hF00D);
        bus(0, 0, 0, 16'h0000, 8'h00);
        finish_run();
    end
endmodule